// File: doc/BRIEF.md
# Feed-Sequence Protected Watchdog Timer

This block is a watchdog timer whose countdown can be restarted only by a two-step key sequence. Software first writes 0xAA to the feed register and then writes 0x55 to it. The counter runs from a watchdog tick. The tick is a single-cycle enable in the bus clock domain, and it passes through a fixed divide-by-4 prescaler. Each group of four ticks lowers the counter by one. A timeout constant of N therefore gives a period of 4·N ticks after a feed.

When the counter expires with both the enable bit and the reset-enable bit set, the block sends a one-cycle reset request to the system reset controller. A sticky timeout flag records the expiry. Only a power-on reset or an explicit software clear removes the flag, so firmware can read it after the system reset to learn why the reset happened. Once software sets the enable bit, software cannot clear it.

The register port has a write side and an independent read side. The read side is combinational, so the live counter can be watched on any cycle.

Top module: `wdt_feedlock`

## Requirements
- R1: After reset the mode register reads 0 in bits 1:0. The timeout constant and the counter both read 0xFF, and `rst_req` is low.
- R2: While the enable bit (mode bit 0) is 0, the counter holds its value whatever `wdt_tick` does.
- R3: While enabled, the counter decrements by exactly one per four `wdt_tick` cycles. It stops at 0.
- R4: A write of 0x55 (data bits 7:0) to the feed register (address 2) reloads the counter from the timeout constant and restarts the prescaler phase. This happens only when the immediately preceding feed-register write carried 0xAA.
- R5: A feed-register write of any value other than 0xAA disarms the sequence. After such a write, a 0x55 does not reload the counter until a fresh 0xAA has been written.
- R6: A mode write with bit 0 set enables the watchdog. A later mode write with bit 0 clear leaves it enabled, and only `rst_n` or `por_n` clears it.
- R7: When a prescaler step takes the counter from 1 to 0 while enabled and mode bit 1 (reset enable) is set, `rst_req` is high for exactly one cycle. That cycle follows the edge on which the counter became 0. The timeout flag (mode bit 2) is set on that same edge.
- R8: If the counter expires while reset enable is 0, the timeout flag is still set, but `rst_req` stays low.
- R9: The timeout flag survives `rst_n`. It is cleared by `por_n` or by a mode write with bit 2 equal to 0. A mode write with bit 2 equal to 1 has no effect on the flag.
- R10: The read map is: address 0 gives the mode register {flag, reset enable, enable} in bits 2:0; address 1 gives the timeout constant; address 2 reads 0; address 3 gives the live counter. A write to address 1 replaces the timeout constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and watchdog clock |
| por_n | input | 1 | Power-on reset, synchronous, active low, clears everything |
| rst_n | input | 1 | System reset, synchronous, active low, keeps the timeout flag |
| wdt_tick | input | 1 | Watchdog clock enable, one pulse per watchdog period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mode, 1 timeout constant, 2 feed |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Combinational read data |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The bench feeds the block several kinds of feed traffic and compares it with a cycle model on every cycle:
- A clean 0xAA/0x55 pair, which must reload the counter.
- 0xAA followed by another value and then 0x55, which must not reload. This separates a checker that tracks only the last write from one that remembers a stale arm.
- Repeated 0xAA before 0x55, which must still reload.

Expiry is tried with reset enable on and off, to tell the reset request apart from the flag. Expiry is also run into `rst_n` and `por_n`, to show which reset keeps the flag.

Random tick gaps, short timeout constants and mixed mode writes then exercise:
- the prescaler phase after a feed;
- a feed that lands on the same cycle as a counter step;
- attempts to clear the enable bit.

// File: rtl/wdt_feedlock.sv
module wdt_feedlock #(
  parameter int          CNT_W    = 32,
  parameter int          PRE_DIV  = 4,
  parameter logic [31:0] TC_RESET = 32'hFF,
  parameter logic [7:0]  KEY_ARM  = 8'hAA,
  parameter logic [7:0]  KEY_FIRE = 8'h55
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        wdt_tick,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        rst_req
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
  localparam logic [1:0] A_MODE = 2'd0, A_TC = 2'd1, A_FEED = 2'd2, A_CNT = 2'd3;

  logic             en_q, rsten_q, flag_q, armed_q, req_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] tc_q, cnt_q;

  wire sys_rst  = !por_n || !rst_n;
  wire wr_mode  = wr_en && wr_addr == A_MODE;
  wire wr_tc    = wr_en && wr_addr == A_TC;
  wire wr_feed  = wr_en && wr_addr == A_FEED;
  wire feed_ok  = wr_feed && armed_q && wr_data[7:0] == KEY_FIRE;
  wire step     = en_q && wdt_tick;
  wire pre_wrap = step && pre_q == PRE_LAST;
  wire dec      = pre_wrap && cnt_q != '0;
  wire expire   = dec && cnt_q == CNT_W'(1) && !feed_ok;

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      en_q    <= 1'b0;
      rsten_q <= 1'b0;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
      pre_q   <= '0;
      tc_q    <= CNT_W'(TC_RESET);
      cnt_q   <= CNT_W'(TC_RESET);
    end else begin
      if (wr_mode && wr_data[0]) en_q <= 1'b1;
      if (wr_mode) rsten_q <= wr_data[1];
      if (wr_tc) tc_q <= wr_data[CNT_W-1:0];
      if (wr_feed) armed_q <= wr_data[7:0] == KEY_ARM;
      if (feed_ok) pre_q <= '0;
      else if (step) pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (feed_ok) cnt_q <= tc_q;
      else if (dec) cnt_q <= cnt_q - 1'b1;
      req_q <= expire && rsten_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) flag_q <= 1'b0;
    else if (expire) flag_q <= 1'b1;
    else if (rst_n && wr_mode && !wr_data[2]) flag_q <= 1'b0;
  end

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = {29'd0, flag_q, rsten_q, en_q};
      A_TC:    rd_data = 32'(tc_q);
      A_CNT:   rd_data = 32'(cnt_q);
      default: rd_data = '0;
    endcase
  end

  assign rst_req = req_q;
endmodule

// File: rtl/wdt_feedlock_chk.sv
module wdt_feedlock_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             por_n,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic             rst_req,
  input logic             en_q,
  input logic             flag_q,
  input logic             armed_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] tc_q
);
  wire feed_wr = wr_en && wr_addr == 2'd2;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !en_q && !feed_wr |=> $stable(cnt_q));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    feed_wr && armed_q && wr_data[7:0] == 8'h55 |=> cnt_q == $past(tc_q));

  // R5
  disarm_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    feed_wr && wr_data[7:0] != 8'hAA |=> !armed_q);

  // R6
  en_sticky_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    en_q |=> en_q);

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    rst_req |=> !rst_req);

  // R7
  req_flag_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    rst_req |-> flag_q && cnt_q == '0);

  // R9
  flag_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    flag_q && !(wr_en && wr_addr == 2'd0 && !wr_data[2]) |=> flag_q);
endmodule

bind wdt_feedlock wdt_feedlock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rst_req(rst_req), .en_q(en_q), .flag_q(flag_q),
  .armed_q(armed_q), .cnt_q(cnt_q), .tc_q(tc_q)
);

// File: tb/tb_wdt_feedlock.sv
module tb_wdt_feedlock;
  logic clk = 0, por_n = 0, rst_n = 0, wdt_tick = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic rst_req;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdt_feedlock dut (.clk(clk), .por_n(por_n), .rst_n(rst_n), .wdt_tick(wdt_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .rst_req(rst_req));

  bit m_en, m_rs, m_fl, m_arm, m_req;
  int m_pre;
  logic [31:0] m_tc = 32'hFF, m_cnt = 32'hFF;

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {29'd0, m_fl, m_rs, m_en};
      2'd1: return m_tc;
      2'd3: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string auto_tag(input logic [1:0] a);
    case (a)
      2'd0: return "R9";
      2'd3: return "R3";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input bit t, input bit we, input logic [1:0] wa,
                      input logic [31:0] wd, input logic [1:0] ra, input string tag);
    bit feed, wrap, dec, expire;
    @(negedge clk);
    wdt_tick = t; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    feed   = we && wa == 2 && m_arm && wd[7:0] == 8'h55;
    wrap   = m_en && t && m_pre == 3;
    dec    = wrap && m_cnt != 0;
    expire = dec && m_cnt == 1 && !feed;
    @(posedge clk);
    #1;
    if (!por_n) m_fl = 0;
    else if (expire) m_fl = 1;
    else if (rst_n && we && wa == 0 && !wd[2]) m_fl = 0;
    if (!por_n || !rst_n) begin
      m_en = 0; m_rs = 0; m_arm = 0; m_req = 0; m_pre = 0;
      m_tc = 32'hFF; m_cnt = 32'hFF;
    end else begin
      m_req = expire && m_rs;
      if (feed) m_cnt = m_tc; else if (dec) m_cnt = m_cnt - 1;
      if (feed) m_pre = 0; else if (m_en && t) m_pre = (m_pre + 1) % 4;
      if (we && wa == 0) begin m_rs = wd[1]; if (wd[0]) m_en = 1; end
      if (we && wa == 1) m_tc = wd;
      if (we && wa == 2) m_arm = wd[7:0] == 8'hAA;
    end
    checks++;
    if (rd_data !== exp_read(ra)) begin
      fails++;
      $display("FAIL %s rd_data[%0d] actual=%h expected=%h", tag == "" ? auto_tag(ra) : tag,
               ra, rd_data, exp_read(ra));
    end
    checks++;
    if (rst_req !== m_req) begin
      fails++;
      $display("FAIL %s rst_req actual=%b expected=%b", tag == "" ? "R7" : tag, rst_req, m_req);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [1:0] ra, input string tag);
    step(0, 1, a, d, ra, tag);
  endtask

  task automatic ticks(input int n, input logic [1:0] ra, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, ra, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    por_n = 0; rst_n = 0;
    m_fl = 0;
    step(0, 0, 0, 0, 0, "R1"); step(0, 0, 0, 0, 0, "R1");
    por_n = 1; rst_n = 1;
    for (int a = 0; a < 4; a++) step(0, 0, 0, 0, a[1:0], "R1");
    // R2: ticks with watchdog disabled
    ticks(12, 3, "R2");
    // R10: timeout constant write
    wr(1, 32'd5, 1, "R10");
    wr(0, 32'h1, 0, "R6");
    ticks(6, 3, "R2");
    // R4: feed pair reloads
    wr(2, 32'hAA, 3, "R4");
    wr(2, 32'h55, 3, "R4");
    // R3 / R8: run to expiry with reset enable off
    ticks(19, 3, "R3");
    step(0, 0, 0, 0, 3, "R3");
    ticks(1, 0, "R8");
    ticks(4, 3, "R8");
    // R6: writing 0 to enable does not disable; bit2=1 keeps flag
    wr(0, 32'h4, 0, "R6");
    ticks(2, 0, "R6");
    // R9: clearing the flag
    wr(0, 32'h0, 0, "R9");
    // R5: broken pair
    wr(1, 32'd3, 1, "R10");
    wr(0, 32'h3, 0, "R6");
    wr(2, 32'hAA, 3, "R5");
    wr(2, 32'h12, 3, "R5");
    wr(2, 32'h55, 3, "R5");
    ticks(3, 3, "R5");
    // R4: repeated arm then fire
    wr(2, 32'hAA, 3, "R4");
    wr(2, 32'hAA, 3, "R4");
    wr(2, 32'h55, 3, "R4");
    // R7: expiry with reset enable on
    ticks(12, 3, "R7");
    ticks(3, 0, "R7");
    // R9: flag survives rst_n, cleared by por_n
    rst_n = 0; step(0, 0, 0, 0, 0, "R9"); rst_n = 1;
    step(0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 3, "R1");
    por_n = 0; step(0, 0, 0, 0, 0, "R9"); por_n = 1;
    step(0, 0, 0, 0, 0, "R9");

    for (int i = 0; i < 8000; i++) begin
      bit t, we;
      logic [1:0] wa;
      logic [31:0] wd;
      int r;
      t  = ($urandom % 4) != 0;
      we = ($urandom % 6) == 0;
      r  = $urandom % 8;
      wa = r < 4 ? 2'd2 : (r < 6 ? 2'd0 : 2'd1);
      case (wa)
        2'd2: begin
          r = $urandom % 5;
          wd = r < 2 ? 32'hAA : (r < 4 ? 32'h55 : $urandom);
        end
        2'd1: wd = 1 + ($urandom % 6);
        default: wd = $urandom % 8;
      endcase
      rst_n = ($urandom % 700) != 0;
      por_n = ($urandom % 2500) != 0;
      step(t, we, wa, wd, 2'($urandom % 4), "");
    end
    rst_n = 1; por_n = 1;
    finish_run();
  end
endmodule